// File: doc/BRIEF.md
# One-Wire Timing Tick Prescaler

This block turns the system clock into a slow timing strobe for a one-wire bus master. The strobe is meant to pulse at 1 MHz. It is pure clock-enable logic: it never makes a clock edge. Instead it raises a one-cycle enable, `tick_o`, once every N system clocks. Logic elsewhere in the master uses that enable to time its bus slots.

The ratio N is set by an 8-bit divisor written through a simple write port. Bit 7 turns the divider on, and a divisor of zero (or any value with bit 7 clear) turns it off. Bits [1:0] give an odd pre-divide of 2k+1, that is 1, 3, 5 or 7. Bits [4:2] give a further divide by 2^n, for n from 0 to 7. The ratio is the product of the two factors, which covers system clocks from 1 MHz to 896 MHz in the allowed steps. Some examples:
- 0x83 divides by 7.
- 0x8E divides by 40.
- 0x9C divides by 128.

Every write restarts both counters, so the tick phase is always known after a change.

The block has a small controller with two states:
- `ST_IDLE`: divider off, both counters held at zero.
- `ST_RUN`: counting.

Its transitions are:
- T_ENABLE: `ST_IDLE` to `ST_RUN` on a write with bit 7 set.
- T_DISABLE: `ST_RUN` to `ST_IDLE` on a write with bit 7 clear.
- T_RESTART: `ST_RUN` to `ST_RUN` on a write with bit 7 set, which clears the counters.
- In each state, no write means the state holds.

Top module: `owire_tick_div`

## Requirements
- R1: After reset the divisor is 0x00, `tick_o` is low and `div_on_o` is low, and no tick appears until a divisor with bit 7 set is written.
- R2: Divisor bits [1:0] = k select an odd pre-divide factor of 2k+1 (1, 3, 5 or 7).
- R3: Divisor bits [4:2] = n select an extra divide by 2^n (1 to 128).
- R4: While enabled, `tick_o` is high for exactly one cycle every (2k+1)·2^n cycles; when that ratio exceeds 1 it is never high in two consecutive cycles.
- R5: `div_on_o` equals bit 7 of the last written divisor, starting in the cycle after the write edge.
- R6: With bit 7 clear (including the value 0x00), `tick_o` stays low and the counters are held at zero.
- R7: A write restarts both counters. For a ratio R, the first tick is high in the cycle that starts R-1 clock edges after the write edge.
- R8: Divisor bits [6:5] have no effect on the tick timing.
- R9: Rewriting the same divisor in the middle of a period restarts the phase from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Divisor write strobe, sampled on the rising clock edge |
| cfg_wdata | input | 8 | Divisor value to write |
| tick_o | output | 1 | One-cycle timing enable |
| div_on_o | output | 1 | High while the divider is enabled |

## Verification
The assertions take three things for granted:
- `cfg_we` and `cfg_wdata` are settled before each rising edge.
- The divisor changes only through a write.
- No tick boundary is expected across a write, since a write redefines the phase.

The bench meets these conditions by driving all inputs on the falling edge and holding `cfg_we` for exactly one cycle. It then watches a full window of at least two periods after each write, computing the expected tick pattern from the decoded fields. Random divisors, weighted toward bit 7 set and including random values in bits [6:5], are mixed with the listed example divisors, a disabled setting and a mid-period rewrite.

// File: rtl/owtd_pkg.sv
package owtd_pkg;

    localparam int DIV_W   = 8;
    localparam int EN_BIT  = 7;
    localparam int ODD_LSB = 0;
    localparam int ODD_W   = 2;
    localparam int EXP_LSB = 2;
    localparam int EXP_W   = 3;

    // counter widths derived from the field widths
    localparam int ODD_CW  = ODD_W + 1;           // holds 2k, k < 2**ODD_W
    localparam int POW_CW  = (1 << EXP_W) - 1;    // holds 2**n - 1

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } owtd_state_e;

endpackage

// File: rtl/owtd_cfg_reg.sv
module owtd_cfg_reg
    import owtd_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [DW-1:0]    wdata,
    output logic             en_o,
    output logic [ODD_W-1:0] odd_sel_o,
    output logic [EXP_W-1:0] exp_sel_o
);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (we) begin
            div_q <= wdata;
        end
    end

    assign en_o      = div_q[EN_BIT];
    assign odd_sel_o = div_q[ODD_LSB +: ODD_W];
    assign exp_sel_o = div_q[EXP_LSB +: EXP_W];

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(div_q)); // R7

endmodule

// File: rtl/owtd_odd_cnt.sv
module owtd_odd_cnt
    import owtd_pkg::*;
#(
    parameter int SW = ODD_W,
    parameter int CW = ODD_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [SW-1:0] sel,
    output logic          wrap_o,
    output logic [CW-1:0] cnt_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    // odd factor 2k+1 -> terminal count 2k
    assign limit  = {sel, 1'b0};
    assign wrap_o = (cnt_q == limit);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || wrap_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_ODD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit); // R2

endmodule

// File: rtl/owtd_pow_cnt.sv
module owtd_pow_cnt
    import owtd_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int CW = POW_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [EW-1:0] exp_sel,
    output logic          wrap_o,
    output logic [CW-1:0] cnt_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    // 2**n - 1 as a low mask of n ones
    assign limit  = ~({CW{1'b1}} << exp_sel);
    assign wrap_o = (cnt_q == limit);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
        end
    end

    AST_POW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit); // R3

    AST_POW_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/owire_tick_div.sv
module owire_tick_div
    import owtd_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [DW-1:0] cfg_wdata,
    output logic          tick_o,
    output logic          div_on_o
);

    owtd_state_e state_q;
    owtd_state_e state_d;

    logic              en;
    logic [ODD_W-1:0]  odd_sel;
    logic [EXP_W-1:0]  exp_sel;
    logic              run;
    logic              cnt_clr;
    logic              odd_wrap;
    logic              pow_wrap;
    logic [ODD_CW-1:0] odd_cnt;
    logic [POW_CW-1:0] pow_cnt;
    logic              unit_ratio;

    owtd_cfg_reg #(.DW(DW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .en_o      (en),
        .odd_sel_o (odd_sel),
        .exp_sel_o (exp_sel)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cfg_we && cfg_wdata[EN_BIT])  state_d = ST_RUN;   // T_ENABLE
            ST_RUN:  if (cfg_we && !cfg_wdata[EN_BIT]) state_d = ST_IDLE;  // T_DISABLE
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        run      = 1'b0;
        div_on_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                run      = 1'b0;
                div_on_o = 1'b0;
            end
            ST_RUN: begin
                run      = 1'b1;
                div_on_o = 1'b1;
            end
            default: begin
                run      = 1'b0;
                div_on_o = 1'b0;
            end
        endcase
    end

    // any write (T_RESTART included) or idle state holds counters at zero
    assign cnt_clr = cfg_we || !run;

    owtd_odd_cnt #(.SW(ODD_W), .CW(ODD_CW)) u_odd (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .sel    (odd_sel),
        .wrap_o (odd_wrap),
        .cnt_o  (odd_cnt)
    );

    owtd_pow_cnt #(.EW(EXP_W), .CW(POW_CW)) u_pow (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .step    (odd_wrap),
        .exp_sel (exp_sel),
        .wrap_o  (pow_wrap),
        .cnt_o   (pow_cnt)
    );

    assign tick_o     = run && odd_wrap && pow_wrap;
    assign unit_ratio = (odd_sel == '0) && (exp_sel == '0);

    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !tick_o); // R6

    AST_IDLE_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (odd_cnt == '0 && pow_cnt == '0)); // R6

    AST_WR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (odd_cnt == '0 && pow_cnt == '0)); // R7

    AST_ON_FOLLOWS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (div_on_o == $past(cfg_wdata[EN_BIT]))); // R5

    AST_ON_MATCHES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        div_on_o == en); // R5

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !cfg_we && !unit_ratio) |=> !tick_o); // R4

endmodule

// File: tb/owire_tick_div_tb_top.sv
module owire_tick_div_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       tick_o;
    logic       div_on_o;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    owire_tick_div dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tick_o    (tick_o),
        .div_on_o  (div_on_o)
    );

    // expected ratio: 0 means disabled
    function automatic int ratio_of(input logic [7:0] d);
        if (!d[7]) return 0;
        return (2 * int'(d[1:0]) + 1) << d[4:2];
    endfunction

    task automatic chk(input string req, input logic act, input logic expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, expv, $time);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // sample n cycles starting in the first cycle after the write edge
    task automatic watch(input logic [7:0] d, input int n, input string req);
        int r;
        r = ratio_of(d);
        for (int k = 0; k < n; k++) begin
            chk({req, " div_on"}, div_on_o, d[7]);
            chk({req, " tick"}, tick_o, (r != 0) && ((k % r) == r - 1));
            @(negedge clk);
        end
    endtask

    task automatic wr_watch(input logic [7:0] d, input string req);
        int r;
        r = ratio_of(d);
        wr(d);
        watch(d, (r == 0) ? 24 : 2 * r + 3, req);
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd7741);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tick after reset", tick_o, 1'b0);
        chk("R1 div_on after reset", div_on_o, 1'b0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R1 quiet after reset", tick_o, 1'b0);
        end

        // R2 odd factors
        wr_watch(8'h80, "R2 odd1");
        wr_watch(8'h81, "R2 odd3");
        wr_watch(8'h82, "R2 odd5");
        wr_watch(8'h83, "R2 odd7");
        // R3 power factors
        wr_watch(8'h84, "R3 pow2");
        wr_watch(8'h88, "R3 pow4");
        wr_watch(8'h9C, "R3 pow128");
        // R4 products
        wr_watch(8'h85, "R4 3x2");
        wr_watch(8'h8E, "R4 5x8");
        wr_watch(8'h93, "R4 7x16");
        wr_watch(8'h9F, "R4 7x128");
        // R6 disabled settings, then R7 first tick after full period
        wr_watch(8'h00, "R6 zero");
        wr_watch(8'h7F, "R6 bit7 clear");
        wr_watch(8'h8A, "R7 enable from idle");
        // R8 reserved bits
        wr_watch(8'hE5, "R8 bits65 set");
        wr_watch(8'hA5, "R8 bit5 set");
        // R9 mid-period rewrite of same value
        wr(8'h88);
        watch(8'h88, 3, "R9 before rewrite");
        wr_watch(8'h88, "R9 after rewrite");
        // R5 flag follows bit7 across toggles
        wr_watch(8'h01, "R5 off");
        wr_watch(8'h81, "R5 on");

        // random mix
        for (int t = 0; t < 30; t++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if (($urandom % 4) != 0) d[7] = 1'b1;
            wr_watch(d, "R4 random");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule